// File: doc/BRIEF.md
# Overcurrent Pulse-Skip and Latch-Off Sequencer

This block decides, per converter channel and in units of switching cycles, how the controller reacts to an overcurrent comparator. On every switching strobe it samples the comparator bit of each channel. A high sample makes the channel skip its next high-side pulse. The first high sample from rest also opens a timed qualification. Further trips within the first eight strobes only cause more skipped pulses. A trip within the next eight strobes latches a chip-wide shutdown. A channel that stays quiet through both windows returns to rest on its own.

A latched shutdown inhibits the high side of every channel and forces power-good low. It is released only when enable is taken low or when the asynchronous supply reset is asserted. When the dual-channel tracking mode is active, the channel that follows the other channel's output (the highest index) has its overcurrent input ignored.

Top module: `oc_seq_top`

## Requirements
- R1: On a strobe with `en` high, the channel's `hs_inhibit` bit takes the value of its effective comparator sample from the next clock edge and holds it until the next strobe.
- R2: `chan_state` carries two bits per channel (channel c at bits 2c+1:2c) with codes 0 idle, 1 first window, 2 second window, 3 latched. A trip sampled at rest moves the channel to code 1.
- R3: Counting the first trip as strobe 0, trips on strobes 1 to 7 cause pulse skipping only and never latch. After strobe 7 is processed the channel shows code 2.
- R4: A trip on any of strobes 8 to 15 moves the channel to code 3.
- R5: If strobes 8 to 15 carry no trip, the channel shows code 0 once strobe 15 is processed, so a trip on strobe 16 opens a new first window.
- R6: While any channel is latched, `fault_shutdown` and `pg_force_low` are high and every `hs_inhibit` bit is high, whatever the comparator inputs do.
- R7: A latched channel stays latched until `en` is low on a clock edge, or until `rst_n` is asserted; either returns it to code 0.
- R8: With `ddr_mode` high, comparator trips on the highest-index channel leave it at code 0 with its skip bit low; the other channels respond normally.
- R9: While `en` is low, every channel holds code 0, strobes are ignored and `hs_inhibit` is all zero.
- R10: A trip sequence on one channel does not change the state code of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low supply reset |
| en | input | 1 | Converter enable; low clears all channels |
| ddr_mode | input | 1 | Tracking mode; masks the highest-index channel's comparator |
| cyc_stb | input | 1 | One-clock strobe per switching cycle |
| oc_trip | input | CHANNELS | Overcurrent comparator bit per channel |
| hs_inhibit | output | CHANNELS | High-side pulse inhibit per channel |
| fault_shutdown | output | 1 | Latched chip-wide shutdown |
| pg_force_low | output | 1 | Pulls power-good low while the fault is latched |
| chan_state | output | 2*CHANNELS | Per-channel sequencer state code |

## Verification
The bench builds the block with two channels and an eight-strobe window, which keeps the full sixteen-strobe sequence within about twenty strobes per run. On each channel it sweeps the position of a single recurrence over strobes 1 to 20 after a first trip, plus a run with no recurrence. After every strobe it compares state, inhibit and fault against values computed from the strobe distance. This covers every first-window position, every second-window position and the reopening at strobe 16. Separate runs cover the masked tracking channel, the disabled state and release by reset and by enable.

// File: rtl/oc_seq_pkg.sv
package oc_seq_pkg;

  typedef enum logic [1:0] {
    OC_IDLE  = 2'd0,
    OC_WIN1  = 2'd1,
    OC_WIN2  = 2'd2,
    OC_LATCH = 2'd3
  } oc_state_e;

endpackage

// File: rtl/oc_trip_mask.sv
module oc_trip_mask #(
  parameter int CHANNELS = 2,
  parameter int TRACK_CH = CHANNELS - 1
) (
  input  logic [CHANNELS-1:0] trip_raw,
  input  logic                track_en,
  output logic [CHANNELS-1:0] trip_eff
);

  for (genvar c = 0; c < CHANNELS; c++) begin : g_mask
    if (c == TRACK_CH) begin : g_track
      assign trip_eff[c] = trip_raw[c] & ~track_en;
    end else begin : g_plain
      assign trip_eff[c] = trip_raw[c];
    end
  end

endmodule

// File: rtl/oc_chan_fsm.sv
module oc_chan_fsm
  import oc_seq_pkg::*;
#(
  parameter int WIN_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       stb,
  input  logic       trip,
  output logic [1:0] state_o,
  output logic       skip_o,
  output logic       latched_o
);

  localparam int CNT_W = $clog2(2 * WIN_CYCLES);
  localparam logic [CNT_W-1:0] LAST_W1 = CNT_W'(WIN_CYCLES - 1);
  localparam logic [CNT_W-1:0] LAST_W2 = CNT_W'(2 * WIN_CYCLES - 1);

  oc_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             skip_q, skip_d;

  // next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    skip_d  = skip_q;
    if (!en) begin
      state_d = OC_IDLE;
      cnt_d   = '0;
      skip_d  = 1'b0;
    end else if (stb) begin
      skip_d = trip;
      unique case (state_q)
        OC_IDLE: begin
          if (trip) begin
            state_d = OC_WIN1;
            cnt_d   = CNT_W'(1);
          end
        end
        OC_WIN1: begin
          if (cnt_q == LAST_W1) state_d = OC_WIN2;
          cnt_d = cnt_q + 1'b1;
        end
        OC_WIN2: begin
          if (trip) begin
            state_d = OC_LATCH;
            cnt_d   = '0;
          end else if (cnt_q == LAST_W2) begin
            state_d = OC_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        OC_LATCH: begin
          state_d = OC_LATCH;
        end
        default: begin
          state_d = OC_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= OC_IDLE;
      cnt_q   <= '0;
      skip_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      skip_q  <= skip_d;
    end
  end

  assign state_o   = state_q;
  assign skip_o    = skip_q;
  assign latched_o = (state_q == OC_LATCH);

  AST_SKIP_ON_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stb && trip) |=> skip_q);  // R1
  AST_WIN1_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == OC_WIN1) |=> (state_q != OC_LATCH));  // R3
  AST_WIN2_TRIP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stb && trip && state_q == OC_WIN2) |=> (state_q == OC_LATCH));  // R4
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q == OC_LATCH) |=> (state_q == OC_LATCH));  // R7
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (state_q == OC_IDLE && !skip_q));  // R9

endmodule

// File: rtl/oc_fault_merge.sv
module oc_fault_merge #(
  parameter int CHANNELS = 2
) (
  input  logic [CHANNELS-1:0] skip,
  input  logic [CHANNELS-1:0] latched,
  output logic [CHANNELS-1:0] hs_inhibit,
  output logic                fault_any,
  output logic                pg_low
);

  always_comb begin
    fault_any = |latched;
    pg_low    = fault_any;
  end

  for (genvar c = 0; c < CHANNELS; c++) begin : g_gate
    assign hs_inhibit[c] = skip[c] | fault_any;
  end

endmodule

// File: rtl/oc_seq_top.sv
module oc_seq_top #(
  parameter int CHANNELS   = 2,
  parameter int WIN_CYCLES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  ddr_mode,
  input  logic                  cyc_stb,
  input  logic [CHANNELS-1:0]   oc_trip,
  output logic [CHANNELS-1:0]   hs_inhibit,
  output logic                  fault_shutdown,
  output logic                  pg_force_low,
  output logic [2*CHANNELS-1:0] chan_state
);

  localparam int TRACK_CH = CHANNELS - 1;

  logic [CHANNELS-1:0] trip_eff;
  logic [CHANNELS-1:0] skip_v;
  logic [CHANNELS-1:0] latch_v;

  oc_trip_mask #(.CHANNELS(CHANNELS), .TRACK_CH(TRACK_CH)) u_mask (
    .trip_raw (oc_trip),
    .track_en (ddr_mode),
    .trip_eff (trip_eff)
  );

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    oc_chan_fsm #(.WIN_CYCLES(WIN_CYCLES)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .stb       (cyc_stb),
      .trip      (trip_eff[c]),
      .state_o   (chan_state[2*c+1 -: 2]),
      .skip_o    (skip_v[c]),
      .latched_o (latch_v[c])
    );
  end

  oc_fault_merge #(.CHANNELS(CHANNELS)) u_merge (
    .skip       (skip_v),
    .latched    (latch_v),
    .hs_inhibit (hs_inhibit),
    .fault_any  (fault_shutdown),
    .pg_low     (pg_force_low)
  );

  AST_TRACK_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ddr_mode && chan_state[2*TRACK_CH+1 -: 2] == 2'd0)
      |=> (chan_state[2*TRACK_CH+1 -: 2] == 2'd0));  // R8
  AST_FAULT_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_shutdown |-> (&hs_inhibit && pg_force_low));  // R6

endmodule

// File: tb/oc_seq_top_test.sv
module oc_seq_top_test;

  localparam int  CH    = 2;
  localparam int  WIN   = 8;
  localparam time TCLK  = 10ns;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en;
  logic          ddr_mode;
  logic          cyc_stb;
  logic [CH-1:0] oc_trip;
  logic [CH-1:0] hs_inhibit;
  logic          fault_shutdown;
  logic          pg_force_low;
  logic [2*CH-1:0] chan_state;

  int n_tests = 0;
  int n_fail  = 0;

  oc_seq_top #(.CHANNELS(CH), .WIN_CYCLES(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .ddr_mode(ddr_mode),
    .cyc_stb(cyc_stb), .oc_trip(oc_trip), .hs_inhibit(hs_inhibit),
    .fault_shutdown(fault_shutdown), .pg_force_low(pg_force_low),
    .chan_state(chan_state)
  );

  always #(TCLK/2) clk = ~clk;

  task automatic check(string req, int actual, int expected);
    n_tests++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // drive one strobe at a falling edge, sample after the rising edge
  task automatic strobe(logic [CH-1:0] trips);
    @(negedge clk);
    cyc_stb = 1'b1;
    oc_trip = trips;
    @(negedge clk);
    cyc_stb = 1'b0;
    oc_trip = '0;
  endtask

  task automatic idle_clocks(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cycle_enable();
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
  endtask

  // expected code after strobe j, first trip at 0, recurrence at k (0 = none)
  function automatic int exp_code(int j, int k);
    int s, d;
    if (k >= 8 && k <= 15 && j >= k) return 3;
    s = (k >= 16 && j >= k) ? k : 0;
    d = j - s;
    if (d <= WIN - 2) return 1;
    if (d <= 2*WIN - 2) return 2;
    return 0;
  endfunction

  function automatic int code_of(int c);
    return int'(chan_state[2*c +: 2]);
  endfunction

  initial begin
    #(200000 * TCLK);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; ddr_mode = 1'b0; cyc_stb = 1'b0; oc_trip = '0;
    idle_clocks(3);
    check("R2 reset state", int'(chan_state), 0);
    check("R6 reset fault", int'(fault_shutdown), 0);
    check("R1 reset inhibit", int'(hs_inhibit), 0);
    rst_n = 1'b1;
    idle_clocks(2);

    // sweep: channel c, recurrence at strobe k (R2..R6, R10)
    for (int c = 0; c < CH; c++) begin
      for (int k = 0; k <= 20; k++) begin
        cycle_enable();
        for (int j = 0; j <= 20; j++) begin
          logic [CH-1:0] t;
          int code, lat;
          t = '0;
          t[c] = (j == 0 || j == k);
          strobe(t);
          idle_clocks(1);
          code = exp_code(j, k);
          lat  = (code == 3);
          if (j <= WIN - 1 && k <= WIN - 1)
            check("R3 window1 state", code_of(c), code);
          else if (k >= WIN && k <= 2*WIN - 1)
            check("R4 window2 state", code_of(c), code);
          else
            check("R5 self-return state", code_of(c), code);
          check("R10 other channel", code_of(1 - c), 0);
          check("R1 skip", int'(hs_inhibit[c]), (t[c] || lat) ? 1 : 0);
          check("R6 other inhibit", int'(hs_inhibit[1 - c]), lat);
          check("R6 fault", int'(fault_shutdown), lat);
          check("R6 pgood low", int'(pg_force_low), lat);
          if (j == 0) check("R2 first trip", code_of(c), 1);
        end
      end
    end

    // R1: inhibit holds between strobes
    cycle_enable();
    strobe(2'b01);
    idle_clocks(3);
    check("R1 hold between strobes", int'(hs_inhibit), 1);
    strobe(2'b00);
    check("R1 cleared on quiet strobe", int'(hs_inhibit), 0);

    // R7: latch stays with quiet strobes, then cleared by enable
    cycle_enable();
    strobe(2'b01);
    for (int j = 1; j < 8; j++) strobe(2'b00);
    strobe(2'b01);
    for (int j = 0; j < 20; j++) strobe(2'b00);
    check("R7 latch persists", code_of(0), 3);
    check("R7 fault persists", int'(fault_shutdown), 1);
    cycle_enable();
    check("R7 enable clears", int'(chan_state), 0);
    check("R7 enable clears fault", int'(fault_shutdown), 0);

    // R7: cleared by reset
    strobe(2'b10);
    for (int j = 1; j < 9; j++) strobe(2'b00);
    strobe(2'b10);
    check("R7 latched before reset", code_of(1), 3);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R7 reset clears", int'(chan_state), 0);
    check("R7 reset clears inhibit", int'(hs_inhibit), 0);

    // R9: disabled ignores strobes
    @(negedge clk); en = 1'b0;
    for (int j = 0; j < 4; j++) begin
      strobe(2'b11);
      check("R9 disabled state", int'(chan_state), 0);
      check("R9 disabled inhibit", int'(hs_inhibit), 0);
    end
    @(negedge clk); en = 1'b1;

    // R8: tracking channel masked, other still active
    ddr_mode = 1'b1;
    for (int j = 0; j < 20; j++) begin
      strobe(2'b10);
      check("R8 tracking state", code_of(1), 0);
      check("R8 tracking skip", int'(hs_inhibit[1]), 0);
    end
    strobe(2'b11);
    check("R8 other channel trips", code_of(0), 1);
    check("R8 other channel skips", int'(hs_inhibit[0]), 1);
    check("R8 tracking still idle", code_of(1), 0);
    ddr_mode = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule